// File: doc/BRIEF.md
# Fractional-Rate Serial Clock Generator

This block makes the serial clock for an SPI-style port from a fixed system clock in two steps. First, a phase accumulator adds a programmable rate word on every system clock cycle. Each time the sum wraps past its modulus, the block produces a one-cycle pulse. These pulses form an intermediate clock whose mean frequency is the system frequency times the rate word over 2^24. With the nominal 200 MHz system clock, a rate word of 0x800000 gives 100 MHz, and 0x666666 gives 80 MHz.

Second, an integer divider counts those pulses. It toggles the serial clock after every (field + 1) pulses, so the serial clock runs at the intermediate rate divided by 2 * (field + 1). The field ranges from 0 to 255, giving division ratios from 2 to 512. Power-of-two rate words give a perfectly regular intermediate clock, and smaller rate words give less jitter for the same output rate. Both programmed values are copied into working registers only when a full serial clock period ends, or while the generator is stopped. This means a reprogram can never shorten a half period.

Top module: `frac_sclk_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `sclk` is 0 and `ssp_tick` is 0.
- R2: The accumulator is 24 bits wide and wraps modulo 2^24. `ssp_tick` is high for exactly one cycle, one cycle after each addition that wrapped. A rate word of 0x800000 therefore gives a pulse on every second cycle, and 0x666666 gives 400 pulses (±1) in 1000 cycles.
- R3: Each half period of `sclk` lasts exactly (`scr_field` + 1) pulses of `ssp_tick`, so one full period spans 2 * (`scr_field` + 1) pulses.
- R4: The division ratio covers both ends of the field: a field of 0 gives a 2-pulse period, and a field of 255 gives a 512-pulse period.
- R5: A new `rate_word` or `scr_field` takes effect only after the current `sclk` period ends, at a high-to-low transition. The half period already in progress keeps its old length.
- R6: An active rate word of zero stops the generator. `sclk` stays 0, no pulses appear, and the accumulator and divider counter are cleared. After a nonzero rate is restored, the first rise of `sclk` comes after exactly (`scr_field` + 1) pulses.
- R7: When `enable` is low, both `sclk` and `ssp_tick` are 0 on the next cycle, and the accumulator and counter are cleared.
- R8: `sclk` changes only in the cycle after an `ssp_tick` pulse, or when the generator stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run request; low stops and clears the generator |
| rate_word | input | 24 | Phase increment added on every cycle |
| scr_field | input | 8 | Divider field; a half period lasts field + 1 pulses |
| ssp_tick | output | 1 | One-cycle pulse per accumulator wrap (intermediate clock) |
| sclk | output | 1 | Serial clock, idle low |

## Verification
Two events can fall in the same cycle. In the first, an accumulator wrap ends an `sclk` period just as a new field or rate word is written. In the second, `enable` drops in the cycle that a pulse is about to toggle `sclk`. The bench provokes the first by rewriting the field right at an `sclk` rise and then timing the remaining high phase and the following period. It provokes the second by dropping `enable` right at a rise while pulses arrive every second cycle. In both cases a behavioural model, updated every cycle, decides which event wins, and the bench compares both outputs against it on every clock.

// File: rtl/sclk_gen_pkg.sv
// Shared defaults for the fractional serial clock generator.
// Assumes nothing beyond plain integer constants.
package sclk_gen_pkg;
    localparam int unsigned DEF_ACC_W = 24;  // phase accumulator width
    localparam int unsigned DEF_DIV_W = 8;   // divider field width
endpackage

// File: rtl/sclk_phase_accum.sv
// Phase accumulator: adds the active rate word every cycle while running
// and registers the wrap carry as a one-cycle intermediate clock pulse.
// Assumes rate is held stable by the caller except at period boundaries.
module sclk_phase_accum #(
    parameter int unsigned ACC_W = sclk_gen_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] rate,
    output logic             tick
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    // Next phase with carry out in the top bit.
    always_comb sum = {1'b0, acc_q} + {1'b0, rate};

    // Advance phase while running, clear it when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (!run) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
            tick  <= sum[ACC_W];
        end
    end

    // R2: a pulse always follows a wrap, which lowers the phase.
    a_r2_tick_means_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (acc_q < $past(acc_q)));
    // R2: without a pulse, a running phase never decreases.
    a_r2_no_tick_grows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !tick) |-> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/sclk_half_divider.sv
// Divider: counts intermediate pulses and toggles the serial clock every
// half_len + 1 pulses; flags the pulse that ends a full period.
// Assumes half_len only changes when period_end is set or run is low.
module sclk_half_divider #(
    parameter int unsigned DIV_W = sclk_gen_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] half_len,
    output logic             sclk,
    output logic             period_end
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Half period completes on the pulse that finds the count at its limit.
    always_comb begin
        wrap       = tick && (cnt_q == half_len);
        period_end = run && wrap && sclk;
    end

    // Count pulses, toggle the clock on wrap, idle low when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the count never passes the active half-period limit.
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= half_len);
    // R8: the clock moves only after a pulse or when stopping.
    a_r8_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> ($past(tick) || !$past(run)));
endmodule

// File: rtl/frac_sclk_gen.sv
// Top: two-stage serial clock generator. Holds working copies of the rate
// word and divider field that reload only at a period end or while stopped.
// Assumes inputs are synchronous to clk.
module frac_sclk_gen #(
    parameter int unsigned ACC_W = sclk_gen_pkg::DEF_ACC_W,
    parameter int unsigned DIV_W = sclk_gen_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [ACC_W-1:0] rate_word,
    input  logic [DIV_W-1:0] scr_field,
    output logic             ssp_tick,
    output logic             sclk
);
    logic [ACC_W-1:0] rate_act_q;
    logic [DIV_W-1:0] scr_act_q;
    logic             run;
    logic             period_end;

    // Generator runs only when enabled with a nonzero working rate.
    always_comb run = enable && (rate_act_q != '0);

    // Working configuration reloads at a period boundary or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_act_q <= '0;
            scr_act_q  <= '0;
        end else if (!run || period_end) begin
            rate_act_q <= rate_word;
            scr_act_q  <= scr_field;
        end
    end

    sclk_phase_accum #(.ACC_W(ACC_W)) u_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .rate (rate_act_q),
        .tick (ssp_tick)
    );

    sclk_half_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (ssp_tick),
        .half_len  (scr_act_q),
        .sclk      (sclk),
        .period_end(period_end)
    );

    // R5: working configuration changes only at a boundary or when stopped.
    a_r5_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(scr_act_q) || !$stable(rate_act_q)) |->
        (!$past(run) || $past(period_end)));
    // R7: disabling idles both outputs on the next cycle.
    a_r7_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sclk && !ssp_tick));
    // R6: a zero working rate idles both outputs on the next cycle.
    a_r6_zero_rate_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_act_q == '0) |=> (!sclk && !ssp_tick));
endmodule

// File: tb/frac_sclk_gen_test.sv
module frac_sclk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [23:0] rate_word = '0;
    logic [7:0]  scr_field = '0;
    logic        ssp_tick;
    logic        sclk;

    always #4 clk = ~clk;  // 125 MHz

    frac_sclk_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rate_word(rate_word),
        .scr_field(scr_field), .ssp_tick(ssp_tick), .sclk(sclk)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  cmp_en  = 0;
    bit  done    = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: phase as integer, pulse counter, working copies.
    longint m_acc;
    bit     m_tick, m_sclk;
    int     m_cnt, m_rate, m_scr;

    always @(posedge clk) begin : ref_model
        bit     reload;
        longint s;
        if (!rst_n) begin
            m_acc = 0; m_tick = 0; m_sclk = 0; m_cnt = 0; m_rate = 0; m_scr = 0;
        end else if (!enable || m_rate == 0) begin
            m_acc = 0; m_tick = 0; m_sclk = 0; m_cnt = 0;
            m_rate = rate_word; m_scr = scr_field;
        end else begin
            reload = 0;
            if (m_tick) begin
                if (m_cnt == m_scr) begin
                    m_cnt = 0;
                    if (m_sclk) begin m_sclk = 0; reload = 1; end
                    else m_sclk = 1;
                end else m_cnt++;
            end
            s      = m_acc + m_rate;
            m_tick = (s >= (64'd1 << 24));
            m_acc  = s % (64'd1 << 24);
            if (reload) begin m_rate = rate_word; m_scr = scr_field; end
        end
    end

    // Compare both outputs with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && cmp_en && !done) begin
            check(ssp_tick == m_tick, "R2 tick vs model", ssp_tick, m_tick);
            check(sclk == m_sclk, "R3 sclk vs model", sclk, m_sclk);
        end
    end

    task automatic wait_rise();
        @(negedge clk);
        while (sclk) @(negedge clk);
        while (!sclk) @(negedge clk);
    endtask

    task automatic measure_period(output int ticks);
        bit seen_low = 0;
        wait_rise();
        ticks = ssp_tick ? 1 : 0;
        forever begin
            @(negedge clk);
            if (sclk && seen_low) break;
            if (!sclk) seen_low = 1;
            if (ssp_tick) ticks++;
        end
    endtask

    task automatic count_ticks(input int cycles, output int ticks, output int highs);
        ticks = 0; highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (ssp_tick) ticks++;
            if (sclk) highs++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int t, h, p;
        repeat (5) @(negedge clk);
        check(sclk == 0, "R1 sclk in reset", sclk, 0);
        check(ssp_tick == 0, "R1 tick in reset", ssp_tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == 0, "R1 sclk after reset", sclk, 0);
        check(ssp_tick == 0, "R1 tick after reset", ssp_tick, 0);
        cmp_en = 1;

        // R2 / R4: half-rate pulses, field 0.
        enable = 1; rate_word = 24'h800000; scr_field = 8'd0;
        repeat (4) @(negedge clk);
        count_ticks(200, t, h);
        check(t == 100, "R2 pulses at 0x800000", t, 100);
        measure_period(p);
        check(p == 2, "R4 period field 0", p, 2);

        // R3: field 3 gives 8-pulse period.
        scr_field = 8'd3;
        measure_period(p);
        measure_period(p);
        check(p == 8, "R3 period field 3", p, 8);

        // R5: rewrite field right at a rise; high phase keeps old length.
        wait_rise();
        scr_field = 8'd1;
        h = ssp_tick ? 1 : 0;
        forever begin
            @(negedge clk);
            if (!sclk) break;
            if (ssp_tick) h++;
        end
        check(h == 4, "R5 high phase keeps old field", h, 4);
        measure_period(p);
        check(p == 4, "R5 new field after boundary", p, 4);

        // R4: field 255 gives 512-pulse period.
        scr_field = 8'd255;
        measure_period(p);
        measure_period(p);
        check(p == 512, "R4 period field 255", p, 512);

        // R2: two-fifths rate word.
        rate_word = 24'h666666; scr_field = 8'd4;
        measure_period(p);
        measure_period(p);
        check(p == 10, "R3 period at 0x666666 field 4", p, 10);
        count_ticks(1000, t, h);
        check(t >= 399 && t <= 401, "R2 pulses at 0x666666", t, 400);

        // R6: zero rate stops; restart begins from cleared counter.
        rate_word = 24'h0;
        repeat (100) @(negedge clk);
        count_ticks(50, t, h);
        check(t == 0, "R6 no pulses at zero rate", t, 0);
        check(h == 0, "R6 sclk low at zero rate", h, 0);
        rate_word = 24'h800000; scr_field = 8'd2;
        t = 0;
        forever begin
            @(negedge clk);
            if (sclk) break;
            if (ssp_tick) t++;
        end
        check(t == 3, "R6 first rise after restart", t, 3);

        // R7: drop enable right at a rise.
        wait_rise();
        enable = 1'b0;
        @(negedge clk);
        check(sclk == 0, "R7 sclk after disable", sclk, 0);
        check(ssp_tick == 0, "R7 tick after disable", ssp_tick, 0);
        count_ticks(20, t, h);
        check(t == 0 && h == 0, "R7 quiet while disabled", t + h, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule